// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Burst Sequencer

This block models a synchronous static memory whose data bus never needs an idle cycle when traffic switches between reads and writes. Commands (address, read/write select, byte enables) are captured on the rising clock edge. The write data for a command arrives on a later edge. Reads and writes can therefore alternate on every cycle while the single data bus stays busy. A static mode input picks registered-output (pipelined) read timing or flow-through read timing. The write-data lag follows the mode: two cycles after the command when pipelined, one cycle when flow-through.

A load command starts a four-beat burst and advance commands step it. The two low address bits follow a linear or an interleaved order. Writes are byte-granular on 9-bit bytes. Three chip enables gate load commands. An asynchronous output enable and an asynchronous doze input both silence the read bus. Doze also makes the block ignore new commands while it keeps the stored contents. In pipelined mode, a read that targets a word whose late write data is arriving in that same cycle returns the merged new data.

Top module: `lw_sram`

## Requirements
- R1: A write command (cont_burst=0, wr_n=0, selected) taken at edge E stores the wdata present at edge E+1 in flow-through mode (reg_out_mode=0) and at edge E+2 in pipelined mode (reg_out_mode=1).
- R2: In flow-through mode, a read command taken at edge E drives its word on rdata with rd_drive=1 from edge E until edge E+1.
- R3: In pipelined mode, a read command taken at edge E drives its word from edge E+1 until edge E+2.
- R4: Reads and writes may alternate on consecutive cycles with no idle cycle. A read always returns the latest written data, including a pipelined read issued one cycle after a partial write to the same word, whose data is still in flight.
- R5: A load sets the burst base. Each following advance (cont_burst=1) moves to beat n = 1, 2, 3, 0, … In linear order (seq_linear=1), the low 2 address bits are base + n modulo 4. The upper address bits stay those of the base.
- R6: In interleaved order (seq_linear=0), the low 2 address bits of beat n are base XOR n.
- R7: byte_wr_n[i]=0 writes bits [9i+8:9i] of the word. Bytes whose enable is 1 keep their old value.
- R8: A load is selected only when ce_a=1, ce_b=1 and ce_c_n=0. A load with any other combination performs no access and ends the burst. Advances that follow it perform no access.
- R9: out_en_n=1 forces rd_drive=0 and rdata=0 at once, whatever read is in progress.
- R10: While doze=1, rd_drive is 0, commands are ignored, and the stored words are kept.
- R11: After reset, rd_drive is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| reg_out_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| cont_burst | input | 1 | 1 advance burst, 0 load new command |
| wr_n | input | 1 | On load: 0 write burst, 1 read burst |
| byte_wr_n | input | 4 | Per-byte write enables, active low, sampled each command cycle |
| addr | input | 6 | Word address on load |
| wdata | input | 36 | Late write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Asynchronous sleep request |
| rdata | output | 36 | Read data, zero when not driven |
| rd_drive | output | 1 | Read bus is driven |

## Verification
The in-line assertions check, on every cycle, the properties local to the control pipeline. Deselected loads and doze cycles start no access. A pipelined read always fills the output register on the next edge. In flow-through mode a queued write commits on the edge after its command. The burst base stays fixed while a burst runs. Only the bench can show the data behaviour end to end: the exact cycle read data appears in each mode, the address sequences in both orders, the byte merging, the in-flight bypass on alternating traffic, and that contents survive doze and deselected writes.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
    parameter int LW_NBYTES = 4;
    parameter int LW_BYTE_W = 9;
    parameter int LW_ADDR_W = 6;
    parameter int LW_BURST  = 4;

    localparam int LW_WORD_W = LW_NBYTES * LW_BYTE_W;
    localparam int LW_BEAT_W = $clog2(LW_BURST);
    localparam int LW_DEPTH  = 1 << LW_ADDR_W;

    typedef logic [LW_WORD_W-1:0] word_t;
    typedef logic [LW_ADDR_W-1:0] addr_t;
    typedef logic [LW_NBYTES-1:0] bmask_t;

    // one access travelling down the command pipeline
    typedef struct packed {
        logic   valid;
        logic   wr;
        addr_t  addr;
        bmask_t be;
    } slot_t;

    function automatic word_t merge_bytes(word_t old_w, word_t new_w, bmask_t be);
        word_t r;
        r = old_w;
        for (int i = 0; i < LW_NBYTES; i++) begin
            if (be[i]) r[i*LW_BYTE_W +: LW_BYTE_W] = new_w[i*LW_BYTE_W +: LW_BYTE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array
    import lw_sram_pkg::*;
(
    input  logic   clk,
    input  logic   wr_en,
    input  addr_t  wr_addr,
    input  bmask_t wr_be,
    input  word_t  wr_data,
    input  addr_t  rd_addr,
    output word_t  rd_data
);
    word_t mem [LW_DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= merge_bytes(mem[wr_addr], wr_data, wr_be);
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lw_burst_seq.sv
`timescale 1ns/1ps
module lw_burst_seq
    import lw_sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  stop,
    input  logic  step,
    input  logic  lin_order,
    input  addr_t start_addr,
    output logic  issue,
    output addr_t issue_addr
);
    typedef struct packed {
        logic                 active;
        addr_t                base;
        logic [LW_BEAT_W-1:0] beat;
    } seq_t;

    seq_t seq_q, seq_d;
    logic [LW_BEAT_W-1:0] beat_nx;

    always_comb begin
        seq_d      = seq_q;
        issue      = 1'b0;
        issue_addr = start_addr;
        beat_nx    = seq_q.beat + 1'b1;
        if (start) begin
            seq_d.active = 1'b1;
            seq_d.base   = start_addr;
            seq_d.beat   = '0;
            issue        = 1'b1;
        end else if (stop) begin
            seq_d.active = 1'b0;
        end else if (step && seq_q.active) begin
            seq_d.beat = beat_nx;
            issue      = 1'b1;
            issue_addr = seq_q.base;
            issue_addr[LW_BEAT_W-1:0] = lin_order ? (seq_q.base[LW_BEAT_W-1:0] + beat_nx)
                                                  : (seq_q.base[LW_BEAT_W-1:0] ^ beat_nx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && !start) |=> (seq_q.base == $past(seq_q.base))); // R5

    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.active && !start) |-> !issue); // R8
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
    import lw_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_out_mode,
    input  logic                 seq_linear,
    input  logic                 ce_a,
    input  logic                 ce_b,
    input  logic                 ce_c_n,
    input  logic                 cont_burst,
    input  logic                 wr_n,
    input  logic [LW_NBYTES-1:0] byte_wr_n,
    input  logic [LW_ADDR_W-1:0] addr,
    input  logic [LW_WORD_W-1:0] wdata,
    input  logic                 out_en_n,
    input  logic                 doze,
    output logic [LW_WORD_W-1:0] rdata,
    output logic                 rd_drive
);
    typedef struct packed {
        slot_t s1;
        slot_t s2;
        logic  kind_wr;
        logic  out_vld;
        word_t out_word;
    } core_t;

    core_t core_q, core_d;

    logic   selected, bs_start, bs_stop, bs_step, bs_issue;
    addr_t  bs_addr;
    logic   arr_we, hit_pending, flow_live;
    addr_t  arr_waddr;
    bmask_t arr_be;
    word_t  arr_rd, fwd_word;

    assign selected = ce_a & ce_b & ~ce_c_n;
    assign bs_start = ~doze & ~cont_burst & selected;
    assign bs_stop  = ~doze & ~cont_burst & ~selected;
    assign bs_step  = ~doze & cont_burst;

    lw_burst_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (bs_start),
        .stop       (bs_stop),
        .step       (bs_step),
        .lin_order  (seq_linear),
        .start_addr (addr),
        .issue      (bs_issue),
        .issue_addr (bs_addr)
    );

    lw_sram_array u_arr (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_addr (arr_waddr),
        .wr_be   (arr_be),
        .wr_data (wdata),
        .rd_addr (core_q.s1.addr),
        .rd_data (arr_rd)
    );

    always_comb begin
        core_d         = core_q;
        core_d.kind_wr = bs_start ? ~wr_n : core_q.kind_wr;
        core_d.s1.valid = bs_issue;
        core_d.s1.wr    = core_d.kind_wr;
        core_d.s1.addr  = bs_addr;
        core_d.s1.be    = ~byte_wr_n;
        core_d.s2       = core_q.s1;

        // pipelined: write in stage 2 gets its data this cycle; forward it
        hit_pending = reg_out_mode & core_q.s2.valid & core_q.s2.wr
                    & (core_q.s2.addr == core_q.s1.addr);
        fwd_word    = hit_pending ? merge_bytes(arr_rd, wdata, core_q.s2.be) : arr_rd;

        core_d.out_vld = reg_out_mode & core_q.s1.valid & ~core_q.s1.wr;
        if (core_d.out_vld) core_d.out_word = fwd_word;

        if (reg_out_mode) begin
            arr_we    = core_q.s2.valid & core_q.s2.wr;
            arr_waddr = core_q.s2.addr;
            arr_be    = core_q.s2.be;
        end else begin
            arr_we    = core_q.s1.valid & core_q.s1.wr;
            arr_waddr = core_q.s1.addr;
            arr_be    = core_q.s1.be;
        end

        flow_live = ~reg_out_mode & core_q.s1.valid & ~core_q.s1.wr;
        rd_drive  = (reg_out_mode ? core_q.out_vld : flow_live) & ~out_en_n & ~doze;
        rdata     = rd_drive ? (reg_out_mode ? core_q.out_word : arr_rd) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !cont_burst && !(ce_a && ce_b && !ce_c_n)) |=> !core_q.s1.valid); // R8

    AST_DOZE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> !core_q.s1.valid); // R10

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_out_mode && core_q.s1.valid && !core_q.s1.wr) |=> core_q.out_vld); // R3

    AST_FLOW_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_out_mode && core_q.s1.valid && core_q.s1.wr) |-> arr_we); // R1
endmodule

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;
    import lw_sram_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, reg_out_mode = 1'b0, seq_linear = 1'b1;
    logic ce_a = 1'b0, ce_b = 1'b0, ce_c_n = 1'b1, cont_burst = 1'b0, wr_n = 1'b1;
    logic [LW_NBYTES-1:0] byte_wr_n = '1;
    logic [LW_ADDR_W-1:0] addr = '0;
    logic [LW_WORD_W-1:0] wdata = '0, rdata;
    logic out_en_n = 1'b0, doze = 1'b0, rd_drive;

    lw_sram uut (.*);

    typedef struct { int due; word_t data; string tag; } exp_t;
    typedef struct { int due; word_t data; } wd_t;
    exp_t expq[$];
    wd_t  wq[$];
    word_t ref_mem [LW_DEPTH];

    int n_cmp = 0, n_bad = 0, ecount = 0;
    bit mode_pipe = 0, lin = 1, nxt_oe_n = 0, nxt_doze = 0, done = 0;
    bit b_act = 0, b_wr = 0;
    addr_t b_base;
    logic [LW_BEAT_W-1:0] b_beat;

    always @(posedge clk) ecount <= ecount + 1;

    task automatic check(bit ok, string tag, word_t act, word_t exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic word_t mkw(int n);
        return {4'(n), 32'(n * 32'h9E3779B1 + (mode_pipe ? 32'h5555 : 32'h0))};
    endfunction

    // one command cycle; ce = {ce_a, ce_b, ce_c_n}, ben active high
    task automatic issue(bit ld, bit wr, addr_t a, bmask_t ben, word_t dat,
                         logic [2:0] ce, string tag);
        int e;
        addr_t eff;
        bit acc;
        @(negedge clk);
        e = ecount + 1;
        out_en_n = nxt_oe_n; doze = nxt_doze; seq_linear = lin;
        cont_burst = ~ld; wr_n = ~wr; addr = a; byte_wr_n = ~ben;
        {ce_a, ce_b, ce_c_n} = ce;
        acc = 0; eff = a;
        if (!nxt_doze) begin
            if (ld && ce == 3'b110) begin
                b_act = 1; b_base = a; b_beat = '0; b_wr = wr; acc = 1;
            end else if (ld) begin
                b_act = 0;
            end else if (b_act) begin
                b_beat = b_beat + 1'b1;
                eff = b_base;
                eff[LW_BEAT_W-1:0] = lin ? b_base[LW_BEAT_W-1:0] + b_beat
                                         : b_base[LW_BEAT_W-1:0] ^ b_beat;
                acc = 1;
            end
        end
        if (acc) begin
            if (b_wr) begin
                for (int i = 0; i < LW_NBYTES; i++)
                    if (ben[i]) ref_mem[eff][i*LW_BYTE_W +: LW_BYTE_W] = dat[i*LW_BYTE_W +: LW_BYTE_W];
                wq.push_back('{e + (mode_pipe ? 2 : 1), dat});
            end else begin
                expq.push_back('{e + (mode_pipe ? 1 : 0), ref_mem[eff], tag});
            end
        end
        wdata = {LW_WORD_W{1'b1}} ^ word_t'(e);
        if (wq.size() > 0 && wq[0].due == e) begin
            wdata = wq[0].data;
            void'(wq.pop_front());
        end
    endtask

    task automatic nop();
        issue(1, 0, '0, '0, '0, 3'b000, "R8");
    endtask

    // monitor: pops expected reads when due, otherwise the bus must be quiet
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (expq.size() > 0 && expq[0].due <= ecount) begin
                e = expq.pop_front();
                if (out_en_n)
                    check(!rd_drive && rdata == '0, "R9", {rd_drive, rdata}, '0);
                else if (doze)
                    check(!rd_drive, "R10", word_t'(rd_drive), '0);
                else
                    check(rd_drive && rdata == e.data && e.due == ecount, e.tag,
                          rd_drive ? rdata : 'x, e.data);
            end else begin
                check(!rd_drive, "R8 idle bus", word_t'(rd_drive), '0);
            end
        end
    end

    task automatic do_reset(bit pipe);
        @(negedge clk);
        rst_n = 0; reg_out_mode = pipe; mode_pipe = pipe; b_act = 0;
        cont_burst = 0; {ce_a, ce_b, ce_c_n} = 3'b000;
        repeat (3) @(negedge clk);
        check(!rd_drive, "R11", word_t'(rd_drive), '0);
        rst_n = 1;
    endtask

    task automatic run_phase(bit pipe);
        do_reset(pipe);
        nop();
        // R1 / R5: linear write burst, then wrapped linear read burst
        lin = 1;
        issue(1, 1, 6'h10, '1, mkw(1), 3'b110, "R1");
        issue(0, 0, '0, '1, mkw(2), 3'b110, "R1");
        issue(0, 0, '0, '1, mkw(3), 3'b110, "R1");
        issue(0, 0, '0, '1, mkw(4), 3'b110, "R1");
        nop(); nop();
        issue(1, 0, 6'h12, '0, '0, 3'b110, "R5");
        repeat (3) issue(0, 0, '0, '0, '0, 3'b110, "R5");
        issue(1, 0, 6'h10, '0, '0, 3'b110, pipe ? "R3" : "R2");
        nop(); nop();
        // R6: interleaved write and read bursts
        lin = 0;
        issue(1, 1, 6'h21, '1, mkw(5), 3'b110, "R6");
        issue(0, 0, '0, '1, mkw(6), 3'b110, "R6");
        issue(0, 0, '0, '1, mkw(7), 3'b110, "R6");
        issue(0, 0, '0, '1, mkw(8), 3'b110, "R6");
        nop(); nop();
        issue(1, 0, 6'h22, '0, '0, 3'b110, "R6");
        repeat (3) issue(0, 0, '0, '0, '0, 3'b110, "R6");
        lin = 1;
        nop(); nop();
        // R7: byte merge
        issue(1, 1, 6'h30, '1, mkw(9), 3'b110, "R7");
        issue(1, 1, 6'h30, 4'b0101, mkw(10), 3'b110, "R7");
        nop(); nop();
        issue(1, 0, 6'h30, '0, '0, 3'b110, "R7");
        // R4: alternating traffic with in-flight bypass
        issue(1, 1, 6'h31, '1, mkw(11), 3'b110, "R4");
        issue(1, 0, 6'h31, '0, '0, 3'b110, "R4");
        issue(1, 1, 6'h32, '1, mkw(12), 3'b110, "R4");
        issue(1, 0, 6'h31, '0, '0, 3'b110, "R4");
        issue(1, 0, 6'h32, '0, '0, 3'b110, "R4");
        issue(1, 1, 6'h30, 4'b1000, mkw(13), 3'b110, "R4");
        issue(1, 0, 6'h30, '0, '0, 3'b110, "R4");
        nop(); nop(); nop();
        // R8: every deselecting enable combination blocks a write
        foreach (mkce[k]) begin
            issue(1, 1, 6'h10, '1, mkw(14), mkce[k], "R8");
            issue(0, 0, '0, '1, mkw(15), 3'b110, "R8");
            nop(); nop();
            issue(1, 0, 6'h10, '0, '0, 3'b110, "R8");
            nop(); nop();
        end
        // R9: output enable hides a read
        nxt_oe_n = 1;
        issue(1, 0, 6'h11, '0, '0, 3'b110, "R9");
        nop(); nop();
        nxt_oe_n = 0;
        nop();
        // R10: doze ignores commands and keeps contents
        nxt_doze = 1;
        issue(1, 1, 6'h12, '1, mkw(16), 3'b110, "R10");
        issue(1, 0, 6'h12, '0, '0, 3'b110, "R10");
        nxt_doze = 0;
        nop();
        issue(1, 0, 6'h12, '0, '0, 3'b110, "R10");
        nop(); nop(); nop();
    endtask

    logic [2:0] mkce [3] = '{3'b010, 3'b100, 3'b111};

    initial begin
        run_phase(0);
        run_phase(1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule